// File: doc/BRIEF.md
# CAN Error Status Interrupt Controller

This block sits next to a CAN protocol engine. It watches the engine's receive and transmit error counters and three single-cycle event strobes: frame sent, frame received, and receive storage overflow. From the counters it works out three error levels: warning, error passive and bus off. Each level, and each of the three events, can latch a pending status bit.

A mask register chooses which pending bits drive the single interrupt line. A small register port lets a CPU do four things:
- read the pending bits;
- write 1s to clear pending bits;
- program the mask and the warning threshold;
- read the live error levels.

Error levels latch only on entry, so a node that stays error passive raises one interrupt and no more.

Top module: `can_err_irq`

## Requirements
- R1: After reset the pending status (address 0) reads 0, the mask (address 1) reads 0, the warning threshold (address 2) reads 96 and `irqOut` is low.
- R2: Error passive is the level where the larger of the two counters is at least 128. Entering that level sets status bit 1.
- R3: Bus off is the level where the transmit counter is at least 256, whatever the receive counter holds. Entering that level sets status bit 2.
- R4: Warning is the level where the larger counter is strictly greater than the threshold. The threshold is written and read at address 2. Entering the warning level sets status bit 0.
- R5: An error level sets its status bit only on entry. While the level persists, a cleared bit stays clear. Leaving the level and entering it again sets the bit again.
- R6: A one-cycle pulse sets a status bit at the next clock edge: `evTxDone` sets bit 3, `evRxDone` sets bit 4 and `evRxOverflow` sets bit 5.
- R7: Writing address 0 clears each status bit written as 1. Status bits written as 0 keep their value.
- R8: If a clear and a new event reach the same status bit in the same cycle, the bit stays set.
- R9: The mask is written and read at address 1, with bit positions matching the status bits. `irqOut` is registered. It is high one cycle after any status bit is set in both status and mask, and low otherwise.
- R10: Address 3 reads the live error levels one cycle after the counters change: warning in bit 0, error passive in bit 1, bus off in bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txErrCnt | input | 9 | Transmit error counter value |
| rxErrCnt | input | 9 | Receive error counter value |
| evTxDone | input | 1 | Frame transmitted successfully (pulse) |
| evRxDone | input | 1 | Frame received successfully (pulse) |
| evRxOverflow | input | 1 | Receive storage overflow (pulse) |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational) |
| irqOut | output | 1 | Interrupt request, active high |

## Verification
A CPU clear and a fresh event can hit the same status bit in the same clock. The same collision can occur between a clear and an error level being entered. The bench provokes the first case by driving a write-1 to address 0 in the same cycle as an event pulse. It provokes the second by clearing while a counter crosses a threshold. In both cases it judges the outcome from the status read after that edge, which must still show the bit. A clear with no event in that cycle must show the bit gone. Sweeps of both counters across every threshold compare the live levels with values computed in the bench.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
  localparam int SRC_COUNT   = 6;
  localparam int SRC_WARN    = 0;
  localparam int SRC_PASSIVE = 1;
  localparam int SRC_BUSOFF  = 2;
  localparam int SRC_TX      = 3;
  localparam int SRC_RX      = 4;
  localparam int SRC_OVF     = 5;

  localparam logic [1:0] ADDR_STATUS = 2'd0;
  localparam logic [1:0] ADDR_MASK   = 2'd1;
  localparam logic [1:0] ADDR_LEVEL  = 2'd2;
  localparam logic [1:0] ADDR_STATE  = 2'd3;

  typedef struct packed {
    logic                 wrMask;
    logic                 wrLevel;
    logic [SRC_COUNT-1:0] clrBits;
  } irq_strobe_t;
endpackage

// File: rtl/can_err_cmp.sv
module can_err_cmp #(
  parameter int CNT_W       = 9,
  parameter int LVL_W       = 8,
  parameter int PASSIVE_LVL = 128,
  parameter int BUSOFF_LVL  = 256
) (
  input  logic [CNT_W-1:0] txErrCnt,
  input  logic [CNT_W-1:0] rxErrCnt,
  input  logic [LVL_W-1:0] warnLevel,
  output logic [2:0]       errLevels
);
  localparam logic [CNT_W-1:0] PASSIVE_V = CNT_W'(PASSIVE_LVL);
  localparam logic [CNT_W-1:0] BUSOFF_V  = CNT_W'(BUSOFF_LVL);

  logic [CNT_W-1:0] maxCnt;
  logic [CNT_W-1:0] warnExt;

  assign maxCnt  = (txErrCnt > rxErrCnt) ? txErrCnt : rxErrCnt;
  assign warnExt = CNT_W'(warnLevel);

  assign errLevels[0] = maxCnt > warnExt;
  assign errLevels[1] = maxCnt >= PASSIVE_V;
  assign errLevels[2] = txErrCnt >= BUSOFF_V;
endmodule

// File: rtl/can_irq_ctrl.sv
module can_irq_ctrl
  import can_irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output irq_strobe_t       strobes
);
  logic unusedWrBits;
  assign unusedWrBits = ^regWrData;

  always_comb begin
    strobes         = '0;
    strobes.wrMask  = regWrEn && (regAddr == ADDR_MASK);
    strobes.wrLevel = regWrEn && (regAddr == ADDR_LEVEL);
    if (regWrEn && (regAddr == ADDR_STATUS))
      strobes.clrBits = regWrData[SRC_COUNT-1:0];
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.wrMask, strobes.wrLevel, |strobes.clrBits})); // R7
  AST_NO_WRITE_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |-> (strobes == '0)); // R7
endmodule

// File: rtl/can_irq_datapath.sv
module can_irq_datapath
  import can_irq_pkg::*;
#(
  parameter int CNT_W       = 9,
  parameter int LVL_W       = 8,
  parameter int DATA_W      = 8,
  parameter int PASSIVE_LVL = 128,
  parameter int BUSOFF_LVL  = 256,
  parameter int WARN_RST    = 96
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  txErrCnt,
  input  logic [CNT_W-1:0]  rxErrCnt,
  input  logic              evTxDone,
  input  logic              evRxDone,
  input  logic              evRxOverflow,
  input  irq_strobe_t       strobes,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqOut
);
  logic [2:0]           condNow;
  logic [2:0]           condQ;
  logic [SRC_COUNT-1:0] setVec;
  logic [SRC_COUNT-1:0] statusQ;
  logic [SRC_COUNT-1:0] maskQ;
  logic [LVL_W-1:0]     levelQ;

  can_err_cmp #(
    .CNT_W(CNT_W), .LVL_W(LVL_W),
    .PASSIVE_LVL(PASSIVE_LVL), .BUSOFF_LVL(BUSOFF_LVL)
  ) u_cmp (
    .txErrCnt (txErrCnt),
    .rxErrCnt (rxErrCnt),
    .warnLevel(levelQ),
    .errLevels(condNow)
  );

  always_ff @(posedge clk) begin
    if (!rstN) condQ <= '0;
    else       condQ <= condNow;
  end

  assign setVec = {evRxOverflow, evRxDone, evTxDone, condNow & ~condQ};

  for (genvar i = 0; i < SRC_COUNT; i++) begin : g_status
    always_ff @(posedge clk) begin
      if (!rstN)          statusQ[i] <= 1'b0;
      else if (setVec[i]) statusQ[i] <= 1'b1;
      else if (strobes.clrBits[i]) statusQ[i] <= 1'b0;
    end
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.clrBits[i] && !setVec[i]) |=> !statusQ[i]); // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
      setVec[i] |=> statusQ[i]); // R8
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ  <= '0;
      levelQ <= LVL_W'(WARN_RST);
      irqOut <= 1'b0;
    end else begin
      if (strobes.wrMask)  maskQ  <= regWrData[SRC_COUNT-1:0];
      if (strobes.wrLevel) levelQ <= regWrData[LVL_W-1:0];
      irqOut <= |(statusQ & maskQ);
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_STATUS: regRdData = DATA_W'(statusQ);
      ADDR_MASK:   regRdData = DATA_W'(maskQ);
      ADDR_LEVEL:  regRdData = DATA_W'(levelQ);
      default:     regRdData = DATA_W'(condQ);
    endcase
  end

  AST_PASSIVE_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (condNow[SRC_PASSIVE] && !condQ[SRC_PASSIVE]) |=> statusQ[SRC_PASSIVE]); // R2
  AST_BUSOFF_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusQ[SRC_BUSOFF]) |-> $past(txErrCnt >= CNT_W'(BUSOFF_LVL))); // R3
  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrLevel |=> $stable(levelQ)); // R4
  AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusQ[SRC_WARN]) |-> !$past(condQ[SRC_WARN])); // R5
  AST_TX_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    evTxDone |=> statusQ[SRC_TX]); // R6
  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    ((statusQ & maskQ) == '0) |=> !irqOut); // R9
endmodule

// File: rtl/can_err_irq.sv
module can_err_irq
  import can_irq_pkg::*;
#(
  parameter int CNT_W       = 9,
  parameter int LVL_W       = 8,
  parameter int DATA_W      = 8,
  parameter int PASSIVE_LVL = 128,
  parameter int BUSOFF_LVL  = 256,
  parameter int WARN_RST    = 96
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  txErrCnt,
  input  logic [CNT_W-1:0]  rxErrCnt,
  input  logic              evTxDone,
  input  logic              evRxDone,
  input  logic              evRxOverflow,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqOut
);
  irq_strobe_t strobes;

  can_irq_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .strobes  (strobes)
  );

  can_irq_datapath #(
    .CNT_W(CNT_W), .LVL_W(LVL_W), .DATA_W(DATA_W),
    .PASSIVE_LVL(PASSIVE_LVL), .BUSOFF_LVL(BUSOFF_LVL), .WARN_RST(WARN_RST)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .txErrCnt    (txErrCnt),
    .rxErrCnt    (rxErrCnt),
    .evTxDone    (evTxDone),
    .evRxDone    (evRxDone),
    .evRxOverflow(evRxOverflow),
    .strobes     (strobes),
    .regAddr     (regAddr),
    .regWrData   (regWrData),
    .regRdData   (regRdData),
    .irqOut      (irqOut)
  );
endmodule

// File: tb/can_err_irq_test.sv
module can_err_irq_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [8:0] txErrCnt = '0;
  logic [8:0] rxErrCnt = '0;
  logic       evTxDone = 1'b0;
  logic       evRxDone = 1'b0;
  logic       evRxOverflow = 1'b0;
  logic       regWrEn = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       irqOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  can_err_irq uut (
    .clk(clk), .rstN(rstN), .txErrCnt(txErrCnt), .rxErrCnt(rxErrCnt),
    .evTxDone(evTxDone), .evRxDone(evRxDone), .evRxOverflow(evRxOverflow),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irqOut(irqOut)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input int got, input int exp);
    nChecks++;
    if (got != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic readReg(input logic [1:0] a, output int val);
    regAddr = a;
    #1;
    val = int'(regRdData);
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    tick();
    regWrEn = 1'b0; regWrData = '0;
  endtask

  function automatic int expLevels(int tx, int rx, int lvl);
    int m;
    m = (tx > rx) ? tx : rx;
    return ((tx >= 256) ? 4 : 0) | ((m >= 128) ? 2 : 0) | ((m > lvl) ? 1 : 0);
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int v;
    tick(); tick();
    rstN = 1'b1;
    tick();
    // R1 reset state
    readReg(2'd0, v); check("R1 status", v, 0);
    readReg(2'd1, v); check("R1 mask", v, 0);
    readReg(2'd2, v); check("R1 level", v, 96);
    check("R1 irq", int'(irqOut), 0);

    // R10 R2 R3 R4: sweep transmit counter at default threshold
    for (int t = 0; t <= 300; t++) begin
      txErrCnt = 9'(t); rxErrCnt = '0;
      tick();
      readReg(2'd3, v); check("R10 tx sweep", v, expLevels(t, 0, 96));
    end
    // R3: receive counter alone never reaches bus off; threshold 200 (R4)
    txErrCnt = '0;
    writeReg(2'd2, 8'd200);
    readReg(2'd2, v); check("R4 level write", v, 200);
    for (int r = 0; r <= 511; r += 3) begin
      rxErrCnt = 9'(r);
      tick();
      readReg(2'd3, v); check("R3 rx sweep", v, expLevels(0, r, 200));
    end
    // mixed counters across several thresholds
    for (int l = 0; l < 256; l += 51) begin
      writeReg(2'd2, 8'(l));
      for (int t = 0; t < 512; t += 37)
        for (int r = 0; r < 512; r += 61) begin
          txErrCnt = 9'(t); rxErrCnt = 9'(r);
          tick();
          readReg(2'd3, v); check("R4 mixed levels", v, expLevels(t, r, l));
        end
    end

    // back to quiet, clear everything
    txErrCnt = '0; rxErrCnt = '0;
    writeReg(2'd2, 8'd96);
    tick();
    writeReg(2'd0, 8'h3F);
    readReg(2'd0, v); check("R7 clear all", v, 0);

    // R2 R4: enter passive (and warning) via receive counter
    rxErrCnt = 9'd130;
    tick();
    readReg(2'd0, v); check("R2 passive entry", v, 3);
    // R5: clear while level persists, must not reappear
    writeReg(2'd0, 8'h03);
    tick(); tick();
    readReg(2'd0, v); check("R5 no retrigger", v, 0);
    // leave and re-enter
    rxErrCnt = 9'd10; tick();
    rxErrCnt = 9'd140; tick();
    readReg(2'd0, v); check("R5 re-entry", v, 3);
    writeReg(2'd0, 8'h03);
    // R3: bus off entry
    txErrCnt = 9'd300; tick();
    readReg(2'd0, v); check("R3 bus off entry", v, 4);
    writeReg(2'd0, 8'h04);
    readReg(2'd0, v); check("R7 clear bus off", v, 0);
    txErrCnt = '0; rxErrCnt = '0; tick();
    writeReg(2'd0, 8'h3F);

    // R8: clear and level entry same cycle
    regWrEn = 1'b1; regAddr = 2'd0; regWrData = 8'h01; rxErrCnt = 9'd100;
    tick();
    regWrEn = 1'b0; regWrData = '0;
    readReg(2'd0, v); check("R8 warn set wins", v, 1);
    writeReg(2'd0, 8'h01);

    // R6: event pulses
    evTxDone = 1'b1; tick(); evTxDone = 1'b0;
    readReg(2'd0, v); check("R6 tx bit3", v, 8);
    evRxDone = 1'b1; tick(); evRxDone = 1'b0;
    readReg(2'd0, v); check("R6 rx bit4", v, 24);
    evRxOverflow = 1'b1; tick(); evRxOverflow = 1'b0;
    readReg(2'd0, v); check("R6 ovf bit5", v, 56);
    // R7: partial clear leaves others
    writeReg(2'd0, 8'h10);
    readReg(2'd0, v); check("R7 partial clear", v, 40);
    // R8: clear and event in same cycle
    regWrEn = 1'b1; regAddr = 2'd0; regWrData = 8'h08; evTxDone = 1'b1;
    tick();
    regWrEn = 1'b0; regWrData = '0; evTxDone = 1'b0;
    readReg(2'd0, v); check("R8 event set wins", v, 40);
    writeReg(2'd0, 8'h3F);
    tick();
    check("R9 irq low unmasked", int'(irqOut), 0);

    // R9: mask and registered irq
    writeReg(2'd1, 8'h10);
    readReg(2'd1, v); check("R9 mask readback", v, 16);
    evTxDone = 1'b1; tick(); evTxDone = 1'b0;
    tick();
    check("R9 irq masked-off source", int'(irqOut), 0);
    evRxDone = 1'b1; tick(); evRxDone = 1'b0;
    check("R9 irq one cycle later", int'(irqOut), 0);
    tick();
    check("R9 irq asserted", int'(irqOut), 1);
    writeReg(2'd0, 8'h10);
    check("R9 irq lag after clear", int'(irqOut), 1);
    tick();
    check("R9 irq dropped", int'(irqOut), 0);
    // every mask bit against every source
    for (int s = 0; s < 3; s++)
      for (int m = 0; m < 64; m += 7) begin
        writeReg(2'd0, 8'h3F);
        writeReg(2'd1, 8'(m));
        evTxDone = (s == 0); evRxDone = (s == 1); evRxOverflow = (s == 2);
        tick();
        evTxDone = 1'b0; evRxDone = 1'b0; evRxOverflow = 1'b0;
        tick();
        check("R9 mask sweep", int'(irqOut), (m >> (s + 3)) & 1);
      end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule